// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block puts a clock generator into a low-power state and brings it back out. An asynchronous active-low request, `pd_n_i`, passes through a synchronizer. The block then waits for the end of each gated clock's current period and parks that output low. Only after all gated outputs are low does it drop the VCO enable, and then the crystal-oscillator enable one cycle later. While the oscillator is off, the serial configuration pins are put into high impedance. The configuration registers sit outside this block and are not touched.

When the request is released, both analog enables come back together. A settle counter then runs for `SETTLE_CYCLES` cycles of `clk`, and the gated outputs stay low for that whole time. After the count the clocks resume, and each one starts with a full high pulse.

The block divides its clock into the gated outputs:
- the CPU and SDRAM clocks have a period of 2 `clk` cycles;
- the PCI and free-running PCI clocks have a period of 4 `clk` cycles.

In power-management mode (`mode_strap_i` = 0), the two stop inputs gate the CPU and PCI clocks. The reference-clock enable is dropped as soon as the synchronized request is seen, independently of the parking sequence. The stop inputs are taken as asynchronous and go through the same synchronizer as the request.

Top module: `clkgen_pd_seq`

## Requirements
- R1: After reset, `vco_en_o`, `xtal_en_o` and `ref_en_o` are 1 and `ser_hiz_o` is 0. The clocks then run: `cpu_clk_o` and `sdram_clk_o` have a period of 2 cycles with 1 cycle high; `pci_clk_o` and `pci_free_clk_o` have a period of 4 cycles with 2 cycles high.
- R2: With `mode_strap_i` = 0, `cpu_stop_n_i` = 0 stops only `cpu_clk_o`, and `pci_stop_n_i` = 0 stops only `pci_clk_o`. `sdram_clk_o` and `pci_free_clk_o` keep running in both cases.
- R3: With `mode_strap_i` = 1, the stop inputs and `pd_n_i` have no effect. All four clocks run and `vco_en_o` stays 1.
- R4: After `pd_n_i` falls in mode 0, all four gated outputs are low within 6 `clk` cycles and stay low. `ref_en_o` is 0 by the 4th cycle, while `vco_en_o` is still 1.
- R5: `vco_en_o` falls only while all gated outputs are held low. `xtal_en_o` falls exactly one cycle after `vco_en_o`. `ser_hiz_o` is 1 only while `vco_en_o` is 0.
- R6: A gated output never produces a shortened or stretched pulse. Every CPU/SDRAM high pulse lasts 1 cycle, and every PCI high pulse lasts 2 cycles. This holds during entry and exit as well.
- R7: While powered down, toggling the stop inputs leaves every gated output low and both analog enables at 0.
- R8: After `pd_n_i` rises, `vco_en_o` and `xtal_en_o` both return to 1 on the 3rd cycle, together with `ser_hiz_o` = 0 and `ref_en_o` = 1. The first `cpu_clk_o` high comes SETTLE_CYCLES+1 or SETTLE_CYCLES+2 cycles after the enables return, and every gated output is low until then.
- R9: If the request is reasserted during the settle period, the block returns to power-down without emitting any output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_i | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n_i | input | 1 | Asynchronous CPU clock stop, active low (mode 0 only) |
| pci_stop_n_i | input | 1 | Asynchronous PCI clock stop, active low (mode 0 only) |
| mode_strap_i | input | 1 | 0 = power-management mode, 1 = stop and power-down inputs ignored |
| cpu_clk_o | output | 1 | Gated CPU clock |
| sdram_clk_o | output | 1 | Gated SDRAM clock |
| pci_clk_o | output | 1 | Gated PCI clock, stoppable |
| pci_free_clk_o | output | 1 | Gated PCI clock, not affected by PCI stop |
| ref_en_o | output | 1 | Reference-clock output enable |
| vco_en_o | output | 1 | VCO enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| ser_hiz_o | output | 1 | Tristate control for the serial configuration pins |

## Verification
Two functions can fall in the same cycle: a stop input releasing its clock, and the power-down request parking every clock. The bench provokes this by releasing `cpu_stop_n_i` on the same edge at which it lowers `pd_n_i`. Because both inputs pass through the same synchronizer, the release and the park decision land on adjacent output slots. The bench judges the result in three ways:
- at most one CPU pulse may escape;
- every output must be low by the sixth cycle;
- the pulse-width assertions must hold throughout, so no shortened or stretched pulse appears.

// File: rtl/clkgen_pd_pkg.sv
package clkgen_pd_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_PARK    = 2'd1,
    ST_OSC_OFF = 2'd2,
    ST_WAKE    = 2'd3
  } pd_state_t;
endpackage

// File: rtl/clkgen_pd_sync.sv
module clkgen_pd_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[gi] <= RST_VAL;
          else     stage_q[gi] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[gi] <= RST_VAL;
          else     stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/clkgen_pd_phase.sv
module clkgen_pd_phase #(
  parameter int PHASE_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic cpu_slot,
  output logic pci_slot,
  output logic pci_low_half,
  output logic cyc_last
);
  localparam logic [PHASE_W-1:0] LAST = '1;

  logic [PHASE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cpu_slot     = ~cnt_q[0];
  assign pci_slot     = (cnt_q == '0);
  assign pci_low_half = cnt_q[PHASE_W-1];
  assign cyc_last     = (cnt_q == LAST);
endmodule

// File: rtl/clkgen_pd_fsm.sv
module clkgen_pd_fsm
  import clkgen_pd_pkg::*;
#(
  parameter int SETTLE_CYCLES = 40000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  logic      outs_low,
  input  logic      cyc_last,
  output pd_state_t state,
  output logic      vco_en,
  output logic      xtal_en,
  output logic      ref_en,
  output logic      ser_hiz
);
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SETTLE_W-1:0] SETTLE_END = SETTLE_W'(SETTLE_CYCLES - 1);

  pd_state_t st_q, st_nxt;
  logic [SETTLE_W-1:0] settle_q;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_RUN:     if (req) st_nxt = ST_PARK;
      ST_PARK:    if (!req) st_nxt = ST_RUN;
                  else if (cyc_last && outs_low) st_nxt = ST_OSC_OFF;
      ST_OSC_OFF: if (!req) st_nxt = ST_WAKE;
      ST_WAKE:    if (req) st_nxt = ST_PARK;
                  else if (settle_q == SETTLE_END) st_nxt = ST_RUN;
      default:    st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      settle_q <= '0;
      vco_en   <= 1'b1;
      xtal_en  <= 1'b1;
      ref_en   <= 1'b1;
      ser_hiz  <= 1'b0;
    end else begin
      st_q     <= st_nxt;
      settle_q <= (st_q == ST_WAKE) ? settle_q + 1'b1 : '0;
      vco_en   <= (st_nxt != ST_OSC_OFF);
      xtal_en  <= vco_en | (st_nxt != ST_OSC_OFF);
      ref_en   <= !req && (st_nxt != ST_OSC_OFF);
      ser_hiz  <= (st_nxt == ST_OSC_OFF);
    end
  end

  assign state = st_q;

  // R5: pins tristated only while the oscillator path is off
  a_r5_hiz_only_when_off: assert property (@(posedge clk) disable iff (rst)
    ser_hiz |-> !vco_en);
  // R5: crystal stops exactly one cycle after the VCO
  a_r5_xtal_after_vco: assert property (@(posedge clk) disable iff (rst)
    $fell(xtal_en) |-> $past(!vco_en) && !vco_en);
  // R8: both analog enables return on the same edge
  a_r8_enables_together: assert property (@(posedge clk) disable iff (rst)
    $rose(vco_en) |-> xtal_en);
endmodule

// File: rtl/clkgen_pd_seq.sv
module clkgen_pd_seq
  import clkgen_pd_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n_i,
  input  logic cpu_stop_n_i,
  input  logic pci_stop_n_i,
  input  logic mode_strap_i,
  output logic cpu_clk_o,
  output logic sdram_clk_o,
  output logic pci_clk_o,
  output logic pci_free_clk_o,
  output logic ref_en_o,
  output logic vco_en_o,
  output logic xtal_en_o,
  output logic ser_hiz_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] sync_q;
  logic pd_n_s, cpu_stop_n_s, pci_stop_n_s;
  logic cpu_slot, pci_slot, pci_low_half, cyc_last;
  logic req_eff, run, want_cpu, want_pci, outs_low;
  pd_state_t state;

  clkgen_pd_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({pci_stop_n_i, cpu_stop_n_i, pd_n_i}),
    .q       (sync_q)
  );
  assign {pci_stop_n_s, cpu_stop_n_s, pd_n_s} = sync_q;

  clkgen_pd_phase #(.PHASE_W(2)) u_phase (
    .clk          (clk),
    .rst          (rst),
    .cpu_slot     (cpu_slot),
    .pci_slot     (pci_slot),
    .pci_low_half (pci_low_half),
    .cyc_last     (cyc_last)
  );

  assign req_eff  = !pd_n_s && !mode_strap_i;
  assign outs_low = !cpu_clk_o && !sdram_clk_o && !pci_clk_o && !pci_free_clk_o;

  clkgen_pd_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (req_eff),
    .outs_low (outs_low),
    .cyc_last (cyc_last),
    .state    (state),
    .vco_en   (vco_en_o),
    .xtal_en  (xtal_en_o),
    .ref_en   (ref_en_o),
    .ser_hiz  (ser_hiz_o)
  );

  assign run      = (state == ST_RUN);
  assign want_cpu = run && (mode_strap_i || cpu_stop_n_s);
  assign want_pci = run && (mode_strap_i || pci_stop_n_s);

  // High phase decided only at the start of a period: no runt pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_o      <= 1'b0;
      sdram_clk_o    <= 1'b0;
      pci_clk_o      <= 1'b0;
      pci_free_clk_o <= 1'b0;
    end else begin
      cpu_clk_o   <= cpu_slot ? want_cpu : 1'b0;
      sdram_clk_o <= cpu_slot ? run : 1'b0;
      if (pci_slot) begin
        pci_clk_o      <= want_pci;
        pci_free_clk_o <= run;
      end else if (pci_low_half) begin
        pci_clk_o      <= 1'b0;
        pci_free_clk_o <= 1'b0;
      end
    end
  end

  // R5: oscillator path off only with every gated output parked
  a_r5_parked_while_off: assert property (@(posedge clk) disable iff (rst)
    !vco_en_o |-> outs_low);
  // R6: CPU and SDRAM pulses are exactly one cycle high
  a_r6_cpu_width: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_o) |=> !cpu_clk_o);
  a_r6_sdram_width: assert property (@(posedge clk) disable iff (rst)
    $rose(sdram_clk_o) |=> !sdram_clk_o);
  // R6: PCI pulses are exactly two cycles high
  a_r6_pci_width: assert property (@(posedge clk) disable iff (rst)
    $rose(pci_clk_o) |=> pci_clk_o ##1 !pci_clk_o);
  a_r6_pcif_width: assert property (@(posedge clk) disable iff (rst)
    $rose(pci_free_clk_o) |=> pci_free_clk_o ##1 !pci_free_clk_o);
  // R8: outputs stay quiet during the settle period
  a_r8_quiet_in_wake: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAKE) |-> outs_low);
  // R3: strap high never lets the VCO turn off
  a_r3_strap_keeps_on: assert property (@(posedge clk) disable iff (rst)
    (mode_strap_i && $past(mode_strap_i)) |-> !$fell(vco_en_o));
endmodule

// File: tb/clkgen_pd_seq_tb.sv
`timescale 1ns/1ps
module clkgen_pd_seq_tb;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_n = 1'b1, cs_n = 1'b1, ps_n = 1'b1, mode = 1'b0;
  logic cpu, sd, pci, pcif, ref_en, vco, xtal, hiz;
  int tests = 0, fails = 0;
  int r_cpu, r_sd, r_pci, r_pcif;
  bit done = 0;

  always #2 clk = ~clk;

  clkgen_pd_seq #(.SYNC_STAGES(2), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst(rst), .pd_n_i(pd_n), .cpu_stop_n_i(cs_n),
    .pci_stop_n_i(ps_n), .mode_strap_i(mode),
    .cpu_clk_o(cpu), .sdram_clk_o(sd), .pci_clk_o(pci), .pci_free_clk_o(pcif),
    .ref_en_o(ref_en), .vco_en_o(vco), .xtal_en_o(xtal), .ser_hiz_o(hiz)
  );

  // {mode, pd_n, cpu_stop_n, pci_stop_n, rises cpu, pci, pci_free, sdram} over 8 cycles
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    {4'b0111, 3'd4, 3'd2, 3'd2, 3'd4},
    {4'b0101, 3'd0, 3'd2, 3'd2, 3'd4},
    {4'b0110, 3'd4, 3'd0, 3'd2, 3'd4},
    {4'b0100, 3'd0, 3'd0, 3'd2, 3'd4},
    {4'b1100, 3'd4, 3'd2, 3'd2, 3'd4},
    {4'b1000, 3'd4, 3'd2, 3'd2, 3'd4},
    {4'b1110, 3'd4, 3'd2, 3'd2, 3'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic window(input int n);
    logic pc, ps, pp, pf;
    r_cpu = 0; r_sd = 0; r_pci = 0; r_pcif = 0;
    pc = cpu; ps = sd; pp = pci; pf = pcif;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpu && !pc) r_cpu++;
      if (sd && !ps) r_sd++;
      if (pci && !pp) r_pci++;
      if (pcif && !pf) r_pcif++;
      pc = cpu; ps = sd; pp = pci; pf = pcif;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int hc, hp, kv, kx, k, first, quiet;
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(vco && xtal && ref_en && !hiz, "R1 enables after reset", {vco, xtal, ref_en, hiz}, 4'b1110);
    tick(6);
    // R1/R6 duty: high samples over 8 cycles
    hc = 0; hp = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      hc += cpu; hp += pci;
    end
    check(hc == 4, "R6 cpu high samples", hc, 4);
    check(hp == 4, "R6 pci high samples", hp, 4);

    // Vector table: R1 R2 R3
    for (int v = 0; v < NV; v++) begin
      {mode, pd_n, cs_n, ps_n} = VEC[v][15:12];
      tick(8);
      window(8);
      check(r_cpu == int'(VEC[v][11:9]), $sformatf("R2/R3 vec%0d cpu", v), r_cpu, VEC[v][11:9]);
      check(r_pci == int'(VEC[v][8:6]), $sformatf("R2/R3 vec%0d pci", v), r_pci, VEC[v][8:6]);
      check(r_pcif == int'(VEC[v][5:3]), $sformatf("R2/R3 vec%0d pci_free", v), r_pcif, VEC[v][5:3]);
      check(r_sd == int'(VEC[v][2:0]), $sformatf("R1 vec%0d sdram", v), r_sd, VEC[v][2:0]);
      check(vco == 1'b1, $sformatf("R3 vec%0d vco on", v), vco, 1);
    end
    mode = 1'b0; pd_n = 1'b1; cs_n = 1'b1; ps_n = 1'b1;
    tick(8);

    // R4/R5/R6: entry colliding with CPU-stop release
    cs_n = 1'b0;
    tick(10);
    pd_n = 1'b0; cs_n = 1'b1;
    kv = -1; kx = -1; r_cpu = 0; quiet = 1;
    for (k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (cpu) r_cpu++;
      if (k == 4) check(!ref_en && vco, "R4 ref off before vco", {ref_en, vco}, 2'b01);
      if (k == 6) check(!cpu && !sd && !pci && !pcif, "R4 parked by cycle 6", {cpu, sd, pci, pcif}, 0);
      if (k >= 6 && (cpu || sd || pci || pcif)) quiet = 0;
      if (kv < 0 && !vco) kv = k;
      if (kx < 0 && !xtal) kx = k;
    end
    check(r_cpu <= 1, "R4 at most one escaped cpu pulse", r_cpu, 1);
    check(quiet == 1, "R4 held low after parking", quiet, 1);
    check(kv > 6, "R5 vco drops after parking", kv, 7);
    check(kx == kv + 1, "R5 xtal one cycle after vco", kx, kv + 1);
    check(hiz == 1'b1, "R5 serial pins tristated", hiz, 1);

    // R7: stops toggled while down
    quiet = 1;
    for (int i = 0; i < 20; i++) begin
      cs_n = i[0]; ps_n = i[1];
      @(negedge clk);
      if (cpu || sd || pci || pcif || vco || xtal) quiet = 0;
    end
    cs_n = 1'b1; ps_n = 1'b1;
    check(quiet == 1, "R7 stops ignored while down", quiet, 1);

    // R8: exit with settle
    pd_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!vco && k < 20);
    check(k == 3, "R8 enables return on cycle 3", k, 3);
    check(xtal && !hiz && ref_en, "R8 xtal/hiz/ref on exit", {xtal, hiz, ref_en}, 3'b101);
    first = -1; quiet = 1;
    for (k = 1; k <= SETTLE + 6; k++) begin
      @(negedge clk);
      if (first < 0 && cpu) first = k;
      if (k <= SETTLE && (cpu || sd || pci || pcif)) quiet = 0;
    end
    check(quiet == 1, "R8 outputs low during settle", quiet, 1);
    check(first == SETTLE + 1 || first == SETTLE + 2, "R8 first cpu pulse", first, SETTLE + 1);

    // R9: re-request inside settle period
    tick(10);
    pd_n = 1'b0;
    tick(30);
    pd_n = 1'b1;
    tick(8);
    pd_n = 1'b0;
    quiet = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cpu || sd || pci || pcif) quiet = 0;
    end
    check(quiet == 1, "R9 no pulse after re-request", quiet, 1);
    check(!vco && hiz, "R9 back in power-down", {vco, hiz}, 2'b01);
    pd_n = 1'b1;
    tick(SETTLE + 10);
    window(8);
    check(r_cpu == 4, "R8 running after final exit", r_cpu, 4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule